// File: doc/BRIEF.md
# Packed Single-to-Half Precision Converter

This block turns a vector of IEEE-754 binary32 values into IEEE-754 binary16 values in one registered step. A mode input selects a narrow operation of four lanes or a wide operation of eight lanes. Each 32-bit input lane lands in the 16-bit output slot with the same index. Output bits above the packed result are driven to zero.

The rounding direction comes from one of two places. The low three bits of a per-operation control byte either carry the direction themselves or point to a two-bit field held in a global control register. That register also supplies a denormals-are-zero bit. Along with the data the block returns five exception flags for the whole operation: invalid, denormal-operand, overflow, underflow and inexact. Each flag is the OR of that flag over the active lanes. Traps and masking belong to the surrounding logic.

Results too small to be normal are always built as half-precision subnormals. There is no flush-to-zero path. A one-deep valid pipeline connects the request to the result.

Top module: `fp32_to_fp16_pack`

## Requirements
- R1: Input lane i (`src[32i+31:32i]`) converts into `dst[16i+15:16i]`. `wide_mode`=0 gives lanes 0..3 and `wide_mode`=1 gives lanes 0..7.
- R2: `dst[255:64]` is zero in narrow mode and `dst[255:128]` is zero in wide mode.
- R3: The rounding source is set by `ctrl_byte[2]`. When it is 0, `ctrl_byte[1:0]` is used and `glb_round` has no effect. When it is 1, `glb_round` is used. Both fields use the same code: 00 = nearest-even, 01 = toward minus infinity, 10 = toward plus infinity, 11 = toward zero.
- R4: `ctrl_byte[7:3]` has no effect on any output.
- R5: Finite normal inputs are rounded correctly in all four directions, including ties to even.
- R6: Results below the smallest normal half value (2^-14) come out as correctly rounded subnormals or signed zero. The underflow flag is set when the exact value is below 2^-14 before rounding and the result is inexact.
- R7: A binary32 subnormal input with `glb_daz`=0 sets the denormal flag. With `glb_daz`=1 it converts to signed zero and raises no flag.
- R8: An infinity gives a signed half infinity. A NaN gives {sign, 11111, 1, input mantissa bits [21:13]}. A signaling NaN (input mantissa bit 22 clear) also sets the invalid flag.
- R9: When the rounded magnitude would exceed 65504, the result is infinity or 0x7BFF with the input sign. Infinity is chosen for nearest-even and for rounding away from zero; 0x7BFF is chosen for rounding toward zero. Both the overflow and inexact flags are set.
- R10: The inexact flag is set exactly when at least one active lane's result differs from its exact value.
- R11: Each flag is the OR over active lanes only. Lanes 4..7 in narrow mode contribute nothing.
- R12: `out_valid` equals `in_valid` delayed by one clock, and `dst` and the flags belong to that request. Reset clears `out_valid`, `dst` and all flags.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| in_valid | input | 1 | Request strobe |
| wide_mode | input | 1 | 1 = eight lanes, 0 = four lanes |
| ctrl_byte | input | 8 | Per-operation control byte (bits 2:0 used) |
| glb_round | input | 2 | Rounding field of the global control register |
| glb_daz | input | 1 | Denormals-are-zero bit of the global control register |
| src | input | 256 | Packed binary32 operands |
| out_valid | output | 1 | Result strobe, one cycle after the request |
| dst | output | 256 | Packed binary16 results, upper bits zero |
| flg_invalid | output | 1 | Signaling NaN seen |
| flg_denorm | output | 1 | Subnormal operand seen with DAZ clear |
| flg_overflow | output | 1 | Result overflowed |
| flg_underflow | output | 1 | Tiny and inexact result |
| flg_precision | output | 1 | Inexact result |

## Verification
The assertions assume that `rst_n` is released away from a clock edge and that every mode and control input is at a defined 0/1 level whenever `in_valid` is high. Their pass conditions are then fixed by the mode bit and the DAZ bit sampled with that request. The bench drives all inputs at the falling edge, so they are stable at each rising edge. It holds `wide_mode`, `ctrl_byte`, `glb_round` and `glb_daz` at known values even while idle. Requests come back to back and with idle gaps, so that the valid pipeline is exercised both ways.

// File: rtl/f2h_pkg.sv
package f2h_pkg;

  typedef enum logic [1:0] {
    RM_NEAR = 2'b00,
    RM_DOWN = 2'b01,
    RM_UP   = 2'b10,
    RM_ZERO = 2'b11
  } f2h_rm_e;

  typedef struct packed {
    logic inv;
    logic den;
    logic ovf;
    logic unf;
    logic pre;
  } f2h_flags_t;

  typedef struct packed {
    logic [15:0] h;
    f2h_flags_t  fl;
  } f2h_res_t;

  // Saturated magnitude on overflow: infinity unless rounding leans toward zero.
  function automatic logic [15:0] f2h_ovf_pick(input logic s, input f2h_rm_e rm);
    logic to_inf;
    case (rm)
      RM_NEAR: to_inf = 1'b1;
      RM_DOWN: to_inf = s;
      RM_UP:   to_inf = !s;
      default: to_inf = 1'b0;
    endcase
    return to_inf ? {s, 15'h7C00} : {s, 15'h7BFF};
  endfunction

  // One lane of binary32 -> binary16 conversion with flags.
  function automatic f2h_res_t f2h_convert(input logic [31:0] x, input f2h_rm_e rm,
                                           input logic daz);
    f2h_res_t    r;
    logic        s;
    logic [7:0]  e;
    logic [22:0] m;
    logic [23:0] sig;
    logic [49:0] wide, shd;
    logic [11:0] kept, rnded;
    logic [16:0] mag;
    logic        rb, sb, inex, inc;
    int          ue, sh;
    r = '0;
    s = x[31];
    e = x[30:23];
    m = x[22:0];
    if (e == 8'hFF) begin
      if (m != '0) begin
        r.h      = {s, 5'h1F, 1'b1, m[21:13]};
        r.fl.inv = !m[22];
      end else begin
        r.h = {s, 15'h7C00};
      end
    end else if (e == 8'h00 && (m == '0 || daz)) begin
      r.h = {s, 15'h0000};
    end else begin
      r.fl.den = (e == 8'h00);
      sig = {e != 8'h00, m};
      ue  = (e == 8'h00) ? -126 : int'(e) - 127;
      if (ue >= 16) begin
        r.fl.ovf = 1'b1;
        r.fl.pre = 1'b1;
        r.h      = f2h_ovf_pick(s, rm);
      end else begin
        sh = (ue >= -14) ? 13 : 13 + (-14 - ue);
        if (sh > 25) sh = 25;
        wide  = {sig, 26'b0};
        shd   = wide >> sh;
        kept  = 12'(shd >> 26);
        rb    = shd[25];
        sb    = |shd[24:0];
        inex  = rb | sb;
        case (rm)
          RM_NEAR: inc = rb & (sb | kept[0]);
          RM_DOWN: inc = inex & s;
          RM_UP:   inc = inex & !s;
          default: inc = 1'b0;
        endcase
        rnded = kept + {11'b0, inc};
        mag   = (ue >= -14) ? (17'(ue + 14) << 10) : 17'd0;
        mag   = mag + {5'b0, rnded};
        if (mag >= 17'h07C00) begin
          r.fl.ovf = 1'b1;
          r.fl.pre = 1'b1;
          r.h      = f2h_ovf_pick(s, rm);
        end else begin
          r.h      = {s, mag[14:0]};
          r.fl.pre = inex;
          r.fl.unf = inex && (ue < -14);
        end
      end
    end
    return r;
  endfunction

endpackage

// File: rtl/f2h_round_sel.sv
module f2h_round_sel
  import f2h_pkg::*;
(
  input  logic [7:0] ctrl_byte,
  input  logic [1:0] glb_round,
  output f2h_rm_e    rm_eff,
  output logic       use_glb
);
  // Only bits 2:0 of the control byte take part in the choice.
  assign use_glb = ctrl_byte[2];
  assign rm_eff  = use_glb ? f2h_rm_e'(glb_round) : f2h_rm_e'(ctrl_byte[1:0]);
endmodule

// File: rtl/f2h_lane.sv
module f2h_lane
  import f2h_pkg::*;
(
  input  logic [31:0] word,
  input  f2h_rm_e     rm,
  input  logic        daz,
  output logic [15:0] half,
  output f2h_flags_t  flags
);
  f2h_res_t res;
  assign res   = f2h_convert(word, rm, daz);
  assign half  = res.h;
  assign flags = res.fl;
endmodule

// File: rtl/fp32_to_fp16_pack.sv
module fp32_to_fp16_pack
  import f2h_pkg::*;
#(
  parameter int LANES  = 8,
  parameter int NARROW = 4
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 in_valid,
  input  logic                 wide_mode,
  input  logic [7:0]           ctrl_byte,
  input  logic [1:0]           glb_round,
  input  logic                 glb_daz,
  input  logic [LANES*32-1:0]  src,
  output logic                 out_valid,
  output logic [LANES*32-1:0]  dst,
  output logic                 flg_invalid,
  output logic                 flg_denorm,
  output logic                 flg_overflow,
  output logic                 flg_underflow,
  output logic                 flg_precision
);
  localparam int SW = 32;
  localparam int HW = 16;
  localparam int BUS_W = LANES * SW;

  f2h_rm_e         rm_eff;
  logic            use_glb;
  logic [HW-1:0]   lane_half  [LANES];
  f2h_flags_t      lane_flags [LANES];
  logic [LANES-1:0] lane_act;
  logic [BUS_W-1:0] dst_nxt;
  f2h_flags_t      flg_nxt, flg_q;

  f2h_round_sel u_rsel (
    .ctrl_byte (ctrl_byte),
    .glb_round (glb_round),
    .rm_eff    (rm_eff),
    .use_glb   (use_glb)
  );

  for (genvar i = 0; i < LANES; i++) begin : g_lane
    f2h_lane u_lane (
      .word  (src[SW*i +: SW]),
      .rm    (rm_eff),
      .daz   (glb_daz),
      .half  (lane_half[i]),
      .flags (lane_flags[i])
    );
    if (i < NARROW) begin : g_always
      assign lane_act[i] = 1'b1;
    end else begin : g_wide_only
      assign lane_act[i] = wide_mode;
    end
  end

  always_comb begin
    dst_nxt = '0;
    flg_nxt = '0;
    for (int i = 0; i < LANES; i++) begin
      if (lane_act[i]) begin
        dst_nxt[HW*i +: HW] = lane_half[i];
        flg_nxt             = flg_nxt | lane_flags[i];
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      out_valid <= 1'b0;
      dst       <= '0;
      flg_q     <= '0;
    end else begin
      out_valid <= in_valid;
      if (in_valid) begin
        dst   <= dst_nxt;
        flg_q <= flg_nxt;
      end
    end
  end

  assign flg_invalid   = flg_q.inv;
  assign flg_denorm    = flg_q.den;
  assign flg_overflow  = flg_q.ovf;
  assign flg_underflow = flg_q.unf;
  assign flg_precision = flg_q.pre;
endmodule

// File: rtl/f2h_pack_chk.sv
module f2h_pack_chk (
  input logic         clk,
  input logic         rst_n,
  input logic         in_valid,
  input logic         wide_mode,
  input logic         glb_daz,
  input logic         out_valid,
  input logic [255:0] dst,
  input logic         flg_denorm,
  input logic         flg_overflow,
  input logic         flg_underflow,
  input logic         flg_precision
);
  // R12
  valid_follow_chk: assert property (@(posedge clk) disable iff (!rst_n)
    in_valid |=> out_valid);
  // R12
  idle_follow_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !in_valid |=> !out_valid);
  // R2
  narrow_upper_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (in_valid && !wide_mode) |=> (dst[255:64] == '0));
  // R2
  wide_upper_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (in_valid && wide_mode) |=> (dst[255:128] == '0));
  // R9
  ovf_inexact_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (out_valid && flg_overflow) |-> flg_precision);
  // R6
  unf_inexact_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (out_valid && flg_underflow) |-> flg_precision);
  // R7
  daz_no_denorm_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (in_valid && glb_daz) |=> !flg_denorm);
endmodule

bind fp32_to_fp16_pack f2h_pack_chk u_chk (
  .clk           (clk),
  .rst_n         (rst_n),
  .in_valid      (in_valid),
  .wide_mode     (wide_mode),
  .glb_daz       (glb_daz),
  .out_valid     (out_valid),
  .dst           (dst),
  .flg_denorm    (flg_denorm),
  .flg_overflow  (flg_overflow),
  .flg_underflow (flg_underflow),
  .flg_precision (flg_precision)
);

// File: tb/fp32_to_fp16_pack_tb.sv
`timescale 1ns/1ps
module fp32_to_fp16_pack_tb;
  logic         clk = 1'b0;
  logic         rst_n = 1'b0;
  logic         in_valid = 1'b0;
  logic         wide_mode = 1'b0;
  logic [7:0]   ctrl_byte = 8'h00;
  logic [1:0]   glb_round = 2'b00;
  logic         glb_daz = 1'b0;
  logic [255:0] src = '0;
  logic         out_valid;
  logic [255:0] dst;
  logic         flg_invalid, flg_denorm, flg_overflow, flg_underflow, flg_precision;

  int n_tests = 0;
  int n_fail  = 0;
  bit finished = 1'b0;

  typedef struct {
    logic [255:0] d;
    logic [4:0]   f;
    string        tag;
  } exp_t;
  exp_t exp_q[$];

  always #2 clk = ~clk;

  fp32_to_fp16_pack u_dut (
    .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .wide_mode(wide_mode),
    .ctrl_byte(ctrl_byte), .glb_round(glb_round), .glb_daz(glb_daz), .src(src),
    .out_valid(out_valid), .dst(dst), .flg_invalid(flg_invalid), .flg_denorm(flg_denorm),
    .flg_overflow(flg_overflow), .flg_underflow(flg_underflow), .flg_precision(flg_precision)
  );

  // Value of a non-negative half bit pattern below infinity.
  function automatic real hmag(int h);
    int he = h >> 10;
    int hf = h & 1023;
    if (he == 0) return hf * (2.0 ** (-24));
    return (1024 + hf) * (2.0 ** (he - 25));
  endfunction

  // Reference: bracket the exact value between two neighbouring halves, then pick.
  // Flag bits {inv, den, ovf, unf, pre}.
  task automatic ref_lane(input logic [31:0] x, input logic [1:0] rm, input logic daz,
                          output logic [15:0] h, output logic [4:0] fl);
    logic s = x[31];
    int   e = int'(x[30:23]);
    int   m = int'(x[22:0]);
    real  a, vlo, vhi, mid;
    int   lo, hi, md, pick;
    logic away, exact, ovf;
    fl = '0;
    if (e == 255) begin
      if (m == 0) h = {s, 15'h7C00};
      else begin
        h = {s, 5'h1F, 1'b1, x[21:13]};
        fl[4] = !x[22];
      end
      return;
    end
    if (e == 0) begin
      if (m != 0 && !daz) fl[3] = 1'b1;
      a = daz ? 0.0 : m * (2.0 ** (-149));
    end else begin
      a = (8388608 + m) * (2.0 ** (e - 150));
    end
    lo = 0;
    hi = 31743;
    while (lo < hi) begin
      md = (lo + hi + 1) / 2;
      if (hmag(md) <= a) lo = md;
      else hi = md - 1;
    end
    vlo   = hmag(lo);
    vhi   = (lo == 31743) ? 65536.0 : hmag(lo + 1);
    exact = (vlo == a);
    away  = (rm == 2'b10 && !s) || (rm == 2'b01 && s);
    if (exact) pick = lo;
    else if (rm == 2'b00) begin
      mid = (vlo + vhi) / 2.0;
      if (a > mid) pick = lo + 1;
      else if (a < mid) pick = lo;
      else pick = (lo % 2 == 0) ? lo : lo + 1;
    end else if (rm == 2'b11) pick = lo;
    else pick = away ? lo + 1 : lo;
    ovf   = (pick == 31744) || (a >= 65536.0);
    h     = {s, 15'(pick)};
    fl[2] = ovf;
    fl[0] = !exact || ovf;
    fl[1] = !exact && !ovf && (a < 2.0 ** (-14));
  endtask

  task automatic check(input string tag, input logic [255:0] act, input logic [255:0] expv,
                       input string what);
    n_tests++;
    if (act !== expv) begin
      n_fail++;
      $display("FAIL %s %s: actual %h expected %h", tag, what, act, expv);
    end
  endtask

  // One request, driven at the falling edge; its expected result is queued.
  task automatic send(input logic wide, input logic [7:0] cb, input logic [1:0] gr,
                      input logic daz, input logic [255:0] data, input string tag);
    exp_t        ex;
    logic [1:0]  rm;
    logic [15:0] h;
    logic [4:0]  fl;
    @(negedge clk);
    in_valid  = 1'b1;
    wide_mode = wide;
    ctrl_byte = cb;
    glb_round = gr;
    glb_daz   = daz;
    src       = data;
    rm   = cb[2] ? gr : cb[1:0];
    ex.d = '0;
    ex.f = '0;
    ex.tag = tag;
    for (int i = 0; i < (wide ? 8 : 4); i++) begin
      ref_lane(data[32*i +: 32], rm, daz, h, fl);
      ex.d[16*i +: 16] = h;
      ex.f = ex.f | fl;
    end
    exp_q.push_back(ex);
  endtask

  task automatic idle(input int n);
    for (int k = 0; k < n; k++) begin
      @(negedge clk);
      in_valid = 1'b0;
    end
  endtask

  function automatic logic [255:0] rep(input logic [31:0] w);
    return {8{w}};
  endfunction

  // Compare on every clock, shortly after the rising edge.
  always @(posedge clk) begin
    logic iv;
    exp_t ex;
    iv = in_valid;
    #1;
    if (rst_n) begin
      check("R12", {255'b0, out_valid}, {255'b0, iv}, "out_valid");
      if (out_valid) begin
        if (exp_q.size() == 0) begin
          check("R12", 256'd1, 256'd0, "unexpected result");
        end else begin
          ex = exp_q.pop_front();
          check(ex.tag, dst, ex.d, "dst");
          check(ex.tag, {251'b0, flg_invalid, flg_denorm, flg_overflow, flg_underflow,
                flg_precision}, {251'b0, ex.f}, "flags {inv,den,ovf,unf,pre}");
        end
      end
    end
  end

  initial begin
    #800000;
    if (!finished) begin
      n_tests++;
      n_fail++;
      $display("FAIL R12 watchdog: actual hung expected done");
      $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
      $finish;
    end
  end

  initial begin
    logic [255:0] v;
    repeat (3) @(negedge clk);
    // R12: reset state
    check("R12", {255'b0, out_valid}, 256'd0, "reset out_valid");
    check("R12", dst, 256'd0, "reset dst");
    check("R12", {251'b0, flg_invalid, flg_denorm, flg_overflow, flg_underflow,
          flg_precision}, 256'd0, "reset flags");
    rst_n = 1'b1;
    idle(2);

    // R1: lane placement, narrow and wide
    send(1'b0, 8'h00, 2'b00, 1'b0, {32'h40A00000, 32'h40800000, 32'h40400000, 32'h40000000,
         32'hC0000000, 32'h3F000000, 32'h3F800000, 32'hBF800000}, "R1");
    send(1'b1, 8'h00, 2'b00, 1'b0, {32'h41000000, 32'h40E00000, 32'h40C00000, 32'h40A00000,
         32'h40800000, 32'h40400000, 32'h40000000, 32'h3F800000}, "R1");
    idle(1);
    // R2 and R11: narrow mode with an SNaN and overflow only in upper lanes
    send(1'b0, 8'h00, 2'b00, 1'b0, {32'h7F800001, 32'h4788B800, 32'h00000001, 32'h7F800001,
         32'h3F800000, 32'h3F800000, 32'h40000000, 32'h3F800000}, "R11");
    send(1'b1, 8'h00, 2'b00, 1'b0, {32'h3F800000, 32'h3F800000, 32'h3F800000, 32'h7F800001,
         32'h3F800000, 32'h3F800000, 32'h3F800000, 32'h3F800000}, "R11");
    send(1'b0, 8'h00, 2'b00, 1'b0, rep(32'h3EAAAAAB), "R2");
    // R3: rounding source
    send(1'b1, 8'h00, 2'b10, 1'b0, rep(32'h3F800001), "R3");
    send(1'b1, 8'h04, 2'b10, 1'b0, rep(32'h3F800001), "R3");
    send(1'b1, 8'h06, 2'b01, 1'b0, rep(32'hBF800001), "R3");
    send(1'b1, 8'h02, 2'b11, 1'b0, rep(32'h3F800001), "R3");
    // R4: upper control bits ignored
    send(1'b1, 8'hF8, 2'b10, 1'b0, rep(32'h3F800001), "R4");
    send(1'b1, 8'hAA, 2'b00, 1'b0, rep(32'h3F800001), "R4");
    send(1'b1, 8'h57, 2'b00, 1'b0, rep(32'hBF800001), "R4");
    // R5: ties and directed modes on normals, both signs
    for (int r = 0; r < 4; r++) begin
      send(1'b1, 8'(r), 2'b00, 1'b0, {32'h3F801000, 32'h3F803000, 32'hBF801000, 32'hBF803000,
           32'h3F801001, 32'hBF801001, 32'h3FFFFFFF, 32'hC2F6E979}, "R5");
    end
    // R6: subnormal results and underflow
    for (int r = 0; r < 4; r++) begin
      send(1'b1, 8'(r), 2'b00, 1'b0, {32'h35800000, 32'h33000000, 32'hB3000000, 32'h33C00000,
           32'h387FC000, 32'h387FF000, 32'h38800000, 32'h2F000000}, "R6");
    end
    // R7: binary32 subnormal inputs with and without DAZ
    send(1'b1, 8'h00, 2'b00, 1'b0, {32'h00000001, 32'h80400000, 32'h3F800000, 32'h00000000,
         32'h80000000, 32'h007FFFFF, 32'h40000000, 32'h3F800000}, "R7");
    send(1'b1, 8'h02, 2'b00, 1'b0, {32'h00000001, 32'h80400000, 32'h3F800000, 32'h3F800000,
         32'h3F800000, 32'h3F800000, 32'h3F800000, 32'h3F800000}, "R7");
    send(1'b1, 8'h06, 2'b10, 1'b1, {32'h00000001, 32'h80400000, 32'h3F800000, 32'h3F800000,
         32'h3F800000, 32'h3F800000, 32'h3F800000, 32'h3F800000}, "R7");
    // R8: NaN and infinity
    send(1'b1, 8'h00, 2'b00, 1'b0, {32'h7FC00001, 32'hFFFFFFFF, 32'h7F800000, 32'hFF800000,
         32'h3F800000, 32'h3F800000, 32'h3F800000, 32'h3F800000}, "R8");
    send(1'b1, 8'h00, 2'b00, 1'b0, {32'h7F800001, 32'hFFA00000, 32'h7FC00000, 32'h3F800000,
         32'h3F800000, 32'h3F800000, 32'h3F800000, 32'h3F800000}, "R8");
    idle(2);
    // R9: overflow in each direction
    for (int r = 0; r < 4; r++) begin
      send(1'b1, 8'(r), 2'b00, 1'b0, {32'h4788B800, 32'hC788B800, 32'h477FF000, 32'hC77FF000,
           32'h477FE000, 32'h477FE001, 32'hD0000000, 32'h50000000}, "R9");
    end
    // R10: inexact and exact mixes
    send(1'b1, 8'h00, 2'b00, 1'b0, rep(32'h3F800000), "R10");
    send(1'b0, 8'h00, 2'b00, 1'b0, {224'h0, 32'h3EAAAAAB}, "R10");
    // R5: random operands with varied modes, gaps and back-to-back requests
    for (int t = 0; t < 400; t++) begin
      for (int i = 0; i < 8; i++) begin
        v[32*i +: 32] = $urandom;
        if ($urandom_range(0, 3) != 0) v[32*i+23 +: 8] = 8'($urandom_range(95, 150));
      end
      send(1'($urandom_range(0, 1)), 8'($urandom), 2'($urandom), 1'($urandom_range(0, 1)),
           v, "R5");
      if ($urandom_range(0, 4) == 0) idle(1);
    end
    idle(4);
    check("R12", {224'b0, 32'(exp_q.size())}, 256'd0, "pending results");
    finished = 1'b1;
    $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end
endmodule